// File: doc/BRIEF.md
# Parallel NOR Flash Word-Program Sequencer

This block sits on the host side of an asynchronous parallel NOR flash and performs one word program per request. A single-cycle start pulse carries the target address and data. The block then drives the chip-select, output-enable and write-strobe lines (all active low), the address bus and the write data bus through four write cycles. The first three write the unlock and program command pattern. The fourth writes the word itself.

The block then watches for the end of the embedded program operation. It issues repeated read cycles of the target address and compares bit 7 of the returned data with bit 7 of the word it wrote. While the flash is still busy, that bit reads back inverted. A match ends the operation with a one-cycle done pulse. If the number of reads reaches a parameterised limit without a match, the operation ends with a one-cycle error pulse instead.

Every interval is counted in system clocks and set by a parameter: setup, strobe low, strobe high, read access and the gap between reads. This lets the bus timing meet the flash limits at any clock rate. The defaults suit a 200 MHz clock. The strobe is low for 55 ns and high for 45 ns, and a read allows 75 ns of access time.

Top module: `flash_word_prog`

## Requirements
- R1: The four write cycles carry, in this order, address 0x5555 with data 0xAA, address 0x2AAA with data 0x55, address 0x5555 with data 0xA0, and then the target address with the target word. Command data is zero in the bits above bit 7, and command addresses are zero above bit 15.
- R2: Each write cycle has three phases. First come SETUP_CYC cycles with chip select low, the write strobe high and address and data driven. Next come WE_LOW_CYC cycles with the write strobe low. Last come WE_HIGH_CYC cycles with both chip select and the write strobe high while address and data stay driven. Output enable stays high through all write cycles, and the address and data do not change while the strobe is low.
- R3: A poll read holds chip select and output enable low with the write strobe high on the target address for ACC_CYC cycles. The returned bit 7 is sampled at the clock edge that ends the last of those cycles. Between two reads there are GAP_CYC cycles with all three strobes high.
- R4: When a sampled bit 7 equals bit 7 of the target word, done is high for exactly the one cycle after that read. Busy is low in that cycle.
- R5: If MAX_POLLS consecutive reads all mismatch, error is high for exactly the one cycle after the last read, and done stays low. If the match comes on read number MAX_POLLS, the result is done.
- R6: The write data bus enable is high only during the three phases of a write cycle. It is low in idle, during reads and during gaps.
- R7: Start is taken only while the block is idle, including the cycle in which done or error is shown. The first write setup cycle appears in the cycle after the accepting clock edge, and busy stays high until the result cycle. A start while busy has no effect.
- R8: After reset all three strobes are high, the data bus enable is low, and busy, done and error are low.
- R9: The target address and data are captured at the accepting edge. Later changes on the request inputs do not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse for one word program |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: program confirmed |
| error | output | 1 | One-cycle pulse: poll limit reached |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Data driven toward the flash |
| fl_wdata_en | output | 1 | Enable for the flash data bus drivers |
| fl_rd_bit7 | input | 1 | Bit 7 of the flash data bus as read |

## Verification
All outputs come straight from the state register. Every result therefore shows up at the falling edge one cycle after the clock edge that causes it. For a start accepted at edge k, the first setup cycle is visible at the falling edge after k. The done or error pulse is visible at the falling edge after the edge that samples the last read. The bench builds a queue of the expected per-cycle bus values when it issues a start. The queue length follows the phase parameters and the number of mismatching reads the flash model will return. The bench then pops and compares one entry at every falling edge, so every strobe, address, data and status value is checked in the exact cycle it is due.

// File: rtl/flash_word_prog.sv
module flash_word_prog #(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int SETUP_CYC   = 1,
  parameter int WE_LOW_CYC  = 11,
  parameter int WE_HIGH_CYC = 9,
  parameter int ACC_CYC     = 15,
  parameter int GAP_CYC     = 4,
  parameter int MAX_POLLS   = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_wdata_en,
  input  logic          fl_rd_bit7
);
  localparam int L1    = (SETUP_CYC > WE_LOW_CYC) ? SETUP_CYC : WE_LOW_CYC;
  localparam int L2    = (WE_HIGH_CYC > ACC_CYC) ? WE_HIGH_CYC : ACC_CYC;
  localparam int L3    = (L1 > L2) ? L1 : L2;
  localparam int MAXL  = (L3 > GAP_CYC) ? L3 : GAP_CYC;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam int PW    = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {IDLE, WSET, WLOW, WHIGH, RACC, RGAP} st_t;

  st_t            st;
  logic [CNT_W-1:0] cnt, len;
  logic [1:0]     step;
  logic [PW-1:0]  polls;
  logic [AW-1:0]  tgt_a;
  logic [DW-1:0]  tgt_d;
  logic           in_write;

  always_comb begin
    case (st)
      WSET:    len = CNT_W'(SETUP_CYC);
      WLOW:    len = CNT_W'(WE_LOW_CYC);
      WHIGH:   len = CNT_W'(WE_HIGH_CYC);
      RACC:    len = CNT_W'(ACC_CYC);
      RGAP:    len = CNT_W'(GAP_CYC);
      default: len = CNT_W'(1);
    endcase
  end

  assign in_write    = (st == WSET) || (st == WLOW) || (st == WHIGH);
  assign busy        = (st != IDLE);
  assign fl_ce_n     = !((st == WSET) || (st == WLOW) || (st == RACC));
  assign fl_we_n     = (st != WLOW);
  assign fl_oe_n     = (st != RACC);
  assign fl_wdata_en = in_write;

  always_comb begin
    fl_addr  = tgt_a;
    fl_wdata = tgt_d;
    if (in_write) begin
      case (step)
        2'd0: begin fl_addr = AW'(16'h5555); fl_wdata = DW'(8'hAA); end
        2'd1: begin fl_addr = AW'(16'h2AAA); fl_wdata = DW'(8'h55); end
        2'd2: begin fl_addr = AW'(16'h5555); fl_wdata = DW'(8'hA0); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      step  <= '0;
      polls <= '0;
      tgt_a <= '0;
      tgt_d <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          tgt_a <= req_addr;
          tgt_d <= req_data;
          step  <= '0;
          polls <= '0;
          cnt   <= '0;
          st    <= WSET;
        end
      end else if (cnt != len - 1'b1) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          WSET:  st <= WLOW;
          WLOW:  st <= WHIGH;
          WHIGH: begin
            if (step == 2'd3) st <= RACC;
            else begin
              step <= step + 1'b1;
              st   <= WSET;
            end
          end
          RACC: begin
            if (fl_rd_bit7 == tgt_d[7]) begin
              done <= 1'b1;
              st   <= IDLE;
            end else if (polls == PW'(MAX_POLLS - 1)) begin
              error <= 1'b1;
              st    <= IDLE;
            end else begin
              polls <= polls + 1'b1;
              st    <= RGAP;
            end
          end
          RGAP:    st <= RACC;
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_word_prog_chk.sv
module flash_word_prog_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic          fl_wdata_en,
  input logic          busy,
  input logic          done,
  input logic          error
);
  // R2
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_wdata_en));

  // R2
  we_fall_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $past(!fl_ce_n && fl_wdata_en));

  // R2
  wlow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  // R6
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wdata_en |-> fl_oe_n);

  // R3
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n));

  // R4
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!busy && $past(busy)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_wdata_en));
endmodule

bind flash_word_prog flash_word_prog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
  .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_wdata_en(fl_wdata_en), .busy(busy), .done(done), .error(error)
);

// File: tb/flash_word_prog_test.sv
module flash_word_prog_test;
  localparam int AW = 18, DW = 16;
  localparam int SU = 2, LO = 3, HI = 2, AC = 3, GP = 2, MP = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, busy, done, error;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_wdata_en, fl_rd_bit7;
  logic [AW-1:0] req_addr, fl_addr;
  logic [DW-1:0] req_data, fl_wdata;

  flash_word_prog #(.AW(AW), .DW(DW), .SETUP_CYC(SU), .WE_LOW_CYC(LO),
    .WE_HIGH_CYC(HI), .ACC_CYC(AC), .GAP_CYC(GP), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .error(error),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wdata_en(fl_wdata_en),
    .fl_rd_bit7(fl_rd_bit7));

  typedef struct packed {
    logic ce, oe, we, den, bsy, dn, er;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0;
  int reads_seen = 0, fail_reads = 0;
  logic [DW-1:0] cur_d = '0;
  logic prev_oe = 1'b1;

  assign fl_rd_bit7 = (reads_seen < fail_reads) ? ~cur_d[7] : cur_d[7];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t ent(logic ce, logic oe, logic we, logic den,
                               logic bsy, logic dn, logic er,
                               logic [AW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.den = den;
    e.bsy = bsy; e.dn = dn; e.er = er; e.a = a; e.d = d;
    return e;
  endfunction

  task automatic push_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    repeat (SU) q.push_back(ent(0, 1, 1, 1, 1, 0, 0, a, d));
    repeat (LO) q.push_back(ent(0, 1, 0, 1, 1, 0, 0, a, d));
    repeat (HI) q.push_back(ent(1, 1, 1, 1, 1, 0, 0, a, d));
  endtask

  task automatic push_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input int k);
    int n;
    push_write(18'h05555, 16'h00AA);
    push_write(18'h02AAA, 16'h0055);
    push_write(18'h05555, 16'h00A0);
    push_write(a, d);
    n = (k + 1 < MP) ? k + 1 : MP;
    for (int i = 0; i < n; i++) begin
      repeat (AC) q.push_back(ent(0, 0, 1, 0, 1, 0, 0, a, '0));
      if (i < n - 1) repeat (GP) q.push_back(ent(1, 1, 1, 0, 1, 0, 0, a, '0));
    end
    q.push_back(ent(1, 1, 1, 0, 0, k < MP, k >= MP, a, '0));
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front() : ent(1, 1, 1, 0, 0, 0, 0, '0, '0);
    chk(fl_ce_n == e.ce, "R2 chip select", fl_ce_n, e.ce);
    chk(fl_we_n == e.we, "R2 write strobe", fl_we_n, e.we);
    chk(fl_oe_n == e.oe, "R3 output enable", fl_oe_n, e.oe);
    chk(fl_wdata_en == e.den, "R6 bus enable", fl_wdata_en, e.den);
    chk(busy == e.bsy, "R7 busy", busy, e.bsy);
    chk(done == e.dn, "R4 done", done, e.dn);
    chk(error == e.er, "R5 error", error, e.er);
    if (!e.ce) chk(fl_addr == e.a, "R1 R9 address", int'(fl_addr), int'(e.a));
    if (e.den) chk(fl_wdata == e.d, "R1 R9 data", int'(fl_wdata), int'(e.d));
    if (fl_oe_n && !prev_oe) reads_seen++;
    prev_oe = fl_oe_n;
  endtask

  // k: number of mismatching reads the flash returns; intf: tick index for a start while busy
  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int k, input int intf);
    int j = 0;
    req_addr = a; req_data = d; cur_d = d;
    fail_reads = k; reads_seen = 0;
    start = 1'b1;
    push_op(a, d, k);
    tick();
    start = 1'b0;
    while (q.size() != 0) begin
      j++;
      if (j == intf) begin
        // R7 R9: start and new request values while busy must change nothing
        start = 1'b1; req_addr = ~a; req_data = ~d;
      end else begin
        start = 1'b0;
      end
      tick();
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R8 strobes in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(!fl_wdata_en && !busy && !done && !error, "R8 status in reset",
        {fl_wdata_en, busy, done, error}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    // R4: immediate match, bit 7 low
    run_op(18'h21234, 16'h0012, 0, 0);
    repeat (2) tick();
    // R4 R7 R9: two mismatching reads, bit 7 high, start while busy in write and in poll
    run_op(18'h3ABCD, 16'h80F0, 2, 9);
    run_op(18'h00100, 16'hFF7F, 1, 31);
    // R5: timeout, then back-to-back start in the error cycle
    run_op(18'h10002, 16'h5A5A, 10, 0);
    // R5 boundary: match on the last allowed read
    run_op(18'h3FFFF, 16'hC3C3, MP - 1, 0);
    // R5 boundary: exactly MAX_POLLS mismatches
    run_op(18'h04444, 16'h0001, MP, 0);
    repeat (3) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule